// File: doc/BRIEF.md
# Reference Qualification Timers

This block takes the raw fault flag that a period monitor produces for one reference clock and turns it into a qualified valid indication. A validation counter requires the reference to stay fault-free for a programmed number of millisecond ticks before valid is raised. Any fault drops valid and clears the count. A second counter watches a reference that stays faulted. When the reference has been faulted for a programmed number of ticks and automatic profile selection is on, the block raises a one-cycle request to reassign the reference to another profile.

Both timeouts are unsigned tick counts, and a timeout of zero switches the matching counter off. With the validation counter off, valid can only be raised by a manual force pulse. Three override inputs are provided for troubleshooting: a kill input, a force-on input and a bypass input. The bypass input shows the raw monitor result directly, without the qualification delay. The reassignment itself happens outside this block.

Top module: `refq_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, valid_o is 0 and redetect_req_o is 0.
- R2: With no override active and val_timeout_i = N > 0, valid_o rises one cycle after the edge that samples the N-th ms_tick_i since the last faulted cycle, provided fault_i stayed 0 throughout. This holds up to N = 2^TW-1.
- R3: A cycle with fault_i = 1 drops valid_o from the next cycle on and clears the validation count. After that, N new fault-free ticks are needed again.
- R4: With val_timeout_i = 0, ticks never raise valid_o. A force_pulse_i sampled while fault_i = 0 raises valid_o one cycle later. A force_pulse_i sampled while fault_i = 1 has no effect.
- R5: A force_pulse_i sampled while fault_i = 0 during a running validation count raises valid_o one cycle later, without waiting for the count.
- R6: When ovr_force_invalid_i = 1, valid_o is 0 in the same cycle, whatever the other inputs are.
- R7: When ovr_force_valid_i = 1 and ovr_force_invalid_i = 0, valid_o is 1 in the same cycle.
- R8: When ovr_bypass_i = 1 and both force overrides are 0, valid_o equals the inverse of fault_i in the same cycle.
- R9: With auto_sel_i = 1 and rdt_timeout_i = M > 0, redetect_req_o is 1 for exactly one cycle after the edge that samples the M-th ms_tick_i of an unbroken faulted stretch. The count then restarts, so a stretch that stays faulted produces one pulse every M ticks.
- R10: Any cycle with fault_i = 0 clears the redetect count.
- R11: redetect_req_o stays 0 whenever auto_sel_i = 0 or rdt_timeout_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| fault_i | input | 1 | Raw fault flag from the period monitor |
| val_timeout_i | input | TW | Validation timeout in ticks, 0 = counter off |
| rdt_timeout_i | input | TW | Redetect timeout in ticks, 0 = counter off |
| auto_sel_i | input | 1 | Automatic profile selection enabled |
| force_pulse_i | input | 1 | Manual validation pulse |
| ovr_force_valid_i | input | 1 | Override: drive valid high |
| ovr_force_invalid_i | input | 1 | Override: drive valid low, highest priority |
| ovr_bypass_i | input | 1 | Override: valid follows the raw fault flag |
| valid_o | output | 1 | Qualified valid indication |
| redetect_req_o | output | 1 | One-cycle reassignment request |

## Verification
The bench builds the block with TW = 4. This puts the all-ones timeout of 15 ticks within reach of a short directed run, so the top boundary of both counters is exercised alongside timeouts of 0 and 1. Random runs with small timeouts and dense ticks cover the following cases:
- a fault arriving in the same cycle as an expiring tick
- a force pulse colliding with an expiry
- a timeout changing while a count is running

// File: rtl/refq_pkg.sv
package refq_pkg;

  typedef struct packed {
    logic kill;
    logic force_on;
    logic bypass;
  } refq_ovr_t;

  typedef enum logic [1:0] {
    SRC_QUAL = 2'd0,
    SRC_RAW  = 2'd1,
    SRC_ONE  = 2'd2,
    SRC_ZERO = 2'd3
  } refq_src_e;

  function automatic refq_src_e refq_pick_src(input refq_ovr_t ovr);
    if (ovr.kill)          return SRC_ZERO;
    else if (ovr.force_on) return SRC_ONE;
    else if (ovr.bypass)   return SRC_RAW;
    else                   return SRC_QUAL;
  endfunction

endpackage

// File: rtl/refq_ms_counter.sv
module refq_ms_counter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] cnt_inc;
  logic          done_d;
  logic          cnt_en;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_en  = clear_i | (run_i & tick_i) | done_o;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (run_i && tick_i) begin
      if (cnt_inc >= limit_i) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  // R9: an expiry pulse is always preceded by a counted tick
  a_r9_done_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tick_i && run_i && !clear_i));

endmodule

// File: rtl/refq_val_state.sv
module refq_val_state (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic force_i,
  input  logic done_i,
  output logic qual_o
);

  logic qual_d;

  always_comb begin
    if (fault_i)               qual_d = 1'b0;
    else if (force_i || done_i) qual_d = 1'b1;
    else                        qual_d = qual_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_o <= 1'b0;
    else        qual_o <= qual_d;
  end

  // R3: a faulted cycle removes qualification on the next edge
  a_r3_fault_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !qual_o);

  // R4: qualification only comes from a force pulse or a timer expiry
  a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(force_i || done_i));

endmodule

// File: rtl/refq_ovr_mux.sv
module refq_ovr_mux
  import refq_pkg::*;
(
  input  refq_ovr_t ovr_i,
  input  logic      fault_i,
  input  logic      qual_i,
  output logic      valid_o
);

  refq_src_e src;

  assign src = refq_pick_src(ovr_i);

  always_comb begin
    unique case (src)
      SRC_ZERO: valid_o = 1'b0;
      SRC_ONE:  valid_o = 1'b1;
      SRC_RAW:  valid_o = ~fault_i;
      default:  valid_o = qual_i;
    endcase
  end

endmodule

// File: rtl/refq_qualifier.sv
module refq_qualifier
  import refq_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick_i,
  input  logic          fault_i,
  input  logic [TW-1:0] val_timeout_i,
  input  logic [TW-1:0] rdt_timeout_i,
  input  logic          auto_sel_i,
  input  logic          force_pulse_i,
  input  logic          ovr_force_valid_i,
  input  logic          ovr_force_invalid_i,
  input  logic          ovr_bypass_i,
  output logic          valid_o,
  output logic          redetect_req_o
);

  logic      qual;
  logic      val_done;
  logic      val_run, val_clear;
  logic      rdt_run, rdt_clear;
  refq_ovr_t ovr;

  assign val_clear = fault_i | qual;
  assign val_run   = ~fault_i & ~qual & (val_timeout_i != '0);
  assign rdt_clear = ~fault_i | ~auto_sel_i | (rdt_timeout_i == '0);
  assign rdt_run   = fault_i;

  refq_ms_counter #(.TW(TW)) u_val_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick_i),
    .run_i   (val_run),
    .clear_i (val_clear),
    .limit_i (val_timeout_i),
    .done_o  (val_done)
  );

  refq_val_state u_val_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_i (fault_i),
    .force_i (force_pulse_i),
    .done_i  (val_done),
    .qual_o  (qual)
  );

  refq_ms_counter #(.TW(TW)) u_rdt_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick_i),
    .run_i   (rdt_run),
    .clear_i (rdt_clear),
    .limit_i (rdt_timeout_i),
    .done_o  (redetect_req_o)
  );

  assign ovr.kill     = ovr_force_invalid_i;
  assign ovr.force_on = ovr_force_valid_i;
  assign ovr.bypass   = ovr_bypass_i;

  refq_ovr_mux u_ovr_mux (
    .ovr_i   (ovr),
    .fault_i (fault_i),
    .qual_i  (qual),
    .valid_o (valid_o)
  );

  // R6: the kill override always wins at the port
  a_r6_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_force_invalid_i |-> !valid_o);

  // R11: no request unless auto selection was on with a nonzero timeout
  a_r11_rdt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    redetect_req_o |-> $past(auto_sel_i && (rdt_timeout_i != '0) && fault_i));

  // R10: a clean cycle can never be followed by a request
  a_r10_clean_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> !redetect_req_o);

endmodule

// File: tb/refq_qualifier_bench.sv
module refq_qualifier_bench;

  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick_i = 1'b0;
  logic          fault_i = 1'b1;
  logic [TW-1:0] val_timeout_i = '0;
  logic [TW-1:0] rdt_timeout_i = '0;
  logic          auto_sel_i = 1'b0;
  logic          force_pulse_i = 1'b0;
  logic          ovr_force_valid_i = 1'b0;
  logic          ovr_force_invalid_i = 1'b0;
  logic          ovr_bypass_i = 1'b0;
  logic          valid_o;
  logic          redetect_req_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int pulses = 0;
  string cur_tag = "R1";
  bit model_on = 1'b0;

  // reference state
  int  m_vcnt, m_rcnt;
  bit  m_vdone, m_qual, m_req;

  always #2 clk = ~clk;

  refq_qualifier #(.TW(TW)) u_refq_qualifier (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i), .fault_i(fault_i),
    .val_timeout_i(val_timeout_i), .rdt_timeout_i(rdt_timeout_i),
    .auto_sel_i(auto_sel_i), .force_pulse_i(force_pulse_i),
    .ovr_force_valid_i(ovr_force_valid_i),
    .ovr_force_invalid_i(ovr_force_invalid_i),
    .ovr_bypass_i(ovr_bypass_i), .valid_o(valid_o),
    .redetect_req_o(redetect_req_o)
  );

  function automatic bit exp_valid();
    if (ovr_force_invalid_i)    return 1'b0;
    else if (ovr_force_valid_i) return 1'b1;
    else if (ovr_bypass_i)      return !fault_i;
    else                        return m_qual;
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // requirement-level model stepped once per edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vcnt = 0; m_rcnt = 0; m_vdone = 0; m_qual = 0; m_req = 0;
    end else begin
      bit nq, nvd, nrq;
      int nvc, nrc;
      nvc = m_vcnt; nvd = 0; nrc = m_rcnt; nrq = 0;
      if (fault_i || m_qual) nvc = 0;
      else if (val_timeout_i != 0 && ms_tick_i) begin
        if (m_vcnt + 1 >= val_timeout_i) begin nvc = 0; nvd = 1; end
        else nvc = m_vcnt + 1;
      end
      if (fault_i) nq = 0;
      else if (force_pulse_i || m_vdone) nq = 1;
      else nq = m_qual;
      if (!fault_i || !auto_sel_i || rdt_timeout_i == 0) nrc = 0;
      else if (ms_tick_i) begin
        if (m_rcnt + 1 >= rdt_timeout_i) begin nrc = 0; nrq = 1; end
        else nrc = m_rcnt + 1;
      end
      m_vcnt = nvc; m_vdone = nvd; m_qual = nq; m_rcnt = nrc; m_req = nrq;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (redetect_req_o === 1'b1) pulses++;
    if (model_on) begin
      chk({cur_tag, " valid"}, valid_o, exp_valid());
      chk({cur_tag, " req"}, redetect_req_o, m_req);
    end
    if (cycles > 100000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 ms_tick_i = 1'b1;
      @(posedge clk); #1 ms_tick_i = 1'b0;
    end
    idle(1);
  endtask

  task automatic fault_blip();
    @(posedge clk); #1 fault_i = 1'b1;
    @(posedge clk); #1 fault_i = 1'b0;
  endtask

  task automatic force_once();
    @(posedge clk); #1 force_pulse_i = 1'b1;
    @(posedge clk); #1 force_pulse_i = 1'b0;
    idle(1);
  endtask

  task automatic at_mid(input string tag, input bit act_sel, input bit exp);
    @(negedge clk);
    chk(tag, act_sel ? redetect_req_o : valid_o, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    int base;
    // R1
    #1;
    chk("R1 valid in reset", valid_o, 1'b0);
    chk("R1 req in reset", redetect_req_o, 1'b0);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 1'b0);
    chk("R1 req after reset", redetect_req_o, 1'b0);
    model_on = 1'b1;

    // R2: timeout 3
    cur_tag = "R2";
    @(posedge clk); #1 val_timeout_i = 4'd3; fault_i = 1'b0;
    ticks(2);
    at_mid("R2 two of three ticks", 1'b0, 1'b0);
    ticks(1);
    at_mid("R2 after third tick", 1'b0, 1'b1);

    // R3: fault restarts the count
    cur_tag = "R3";
    fault_blip();
    at_mid("R3 fault drops valid", 1'b0, 1'b0);
    ticks(2);
    fault_blip();
    ticks(2);
    at_mid("R3 count restarted", 1'b0, 1'b0);
    ticks(1);
    at_mid("R3 revalidated", 1'b0, 1'b1);

    // R2 boundary at all-ones timeout
    cur_tag = "R2";
    @(posedge clk); #1 val_timeout_i = 4'd15;
    fault_blip();
    ticks(14);
    at_mid("R2 max minus one", 1'b0, 1'b0);
    ticks(1);
    at_mid("R2 max timeout", 1'b0, 1'b1);

    // R4: timer off
    cur_tag = "R4";
    @(posedge clk); #1 val_timeout_i = 4'd0;
    fault_blip();
    ticks(20);
    at_mid("R4 ticks ignored", 1'b0, 1'b0);
    @(posedge clk); #1 fault_i = 1'b1;
    force_once();
    @(posedge clk); #1 fault_i = 1'b0;
    idle(1);
    at_mid("R4 force while faulted ignored", 1'b0, 1'b0);
    force_once();
    at_mid("R4 force validates", 1'b0, 1'b1);

    // R5: force during a running count
    cur_tag = "R5";
    @(posedge clk); #1 val_timeout_i = 4'd10;
    fault_blip();
    ticks(3);
    at_mid("R5 counting", 1'b0, 1'b0);
    force_once();
    at_mid("R5 force ends count", 1'b0, 1'b1);

    // R6, R7, R8 overrides
    cur_tag = "R6";
    @(posedge clk); #1 ovr_force_invalid_i = 1'b1; ovr_force_valid_i = 1'b1; ovr_bypass_i = 1'b1;
    at_mid("R6 kill beats all", 1'b0, 1'b0);
    cur_tag = "R7";
    @(posedge clk); #1 ovr_force_invalid_i = 1'b0; fault_i = 1'b1;
    at_mid("R7 force on while faulted", 1'b0, 1'b1);
    cur_tag = "R8";
    @(posedge clk); #1 ovr_force_valid_i = 1'b0;
    at_mid("R8 bypass faulted", 1'b0, 1'b0);
    @(posedge clk); #1 fault_i = 1'b0;
    at_mid("R8 bypass clean without qualification", 1'b0, 1'b1);
    @(posedge clk); #1 ovr_bypass_i = 1'b0;

    // R9: redetect pulses
    cur_tag = "R9";
    @(posedge clk); #1 auto_sel_i = 1'b1; rdt_timeout_i = 4'd3; fault_i = 1'b1;
    base = pulses;
    ticks(2);
    chk("R9 no pulse before expiry", pulses == base, 1'b1);
    ticks(1);
    chk("R9 one pulse at expiry", pulses == base + 1, 1'b1);
    ticks(3);
    chk("R9 restart gives second pulse", pulses == base + 2, 1'b1);

    // R10: clean cycle clears
    cur_tag = "R10";
    base = pulses;
    ticks(2);
    @(posedge clk); #1 fault_i = 1'b0;
    @(posedge clk); #1 fault_i = 1'b1;
    ticks(2);
    chk("R10 count cleared by clean cycle", pulses == base, 1'b1);
    ticks(1);
    chk("R10 pulse after full stretch", pulses == base + 1, 1'b1);

    // R11: gating
    cur_tag = "R11";
    base = pulses;
    @(posedge clk); #1 auto_sel_i = 1'b0;
    ticks(10);
    chk("R11 manual selection no req", pulses == base, 1'b1);
    @(posedge clk); #1 auto_sel_i = 1'b1; rdt_timeout_i = 4'd0;
    ticks(10);
    chk("R11 zero timeout no req", pulses == base, 1'b1);

    // random mix checked against the model every cycle
    cur_tag = "R3";
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      ms_tick_i           = ($urandom % 3) == 0;
      fault_i             = ($urandom % 8) < (fault_i ? 6 : 1);
      force_pulse_i       = ($urandom % 40) == 0;
      ovr_force_invalid_i = ($urandom % 50) == 0;
      ovr_force_valid_i   = ($urandom % 50) == 0;
      ovr_bypass_i        = ($urandom % 30) == 0;
      auto_sel_i          = ($urandom % 20) != 0;
      if (($urandom % 100) == 0) val_timeout_i = TW'($urandom % 5);
      if (($urandom % 100) == 0) rdt_timeout_i = TW'($urandom % 5);
    end
    idle(2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule